// File: doc/BRIEF.md
# Shared Pin Function Selector

This block holds the control bits for a group of I/O pins that several functions share, and turns them into one select vector per pin. A pin can carry plain general I/O, a timer signal, a serial-interface signal, or a DMA signal output. Software writes and reads three small registers through a simple bus port. The pad multiplexers and the peripherals stay outside the block. They use the per-pin one-hot vectors to decide which source drives each pad.

There are two kinds of pin. Each of the `NUM_EXT` extension pins becomes a DMA output when its extension bit is set. When that bit is clear, its port-function bit chooses between general I/O and a serial channel 1 output. The two serial pins, a ready pin and a clock pin, take their serial function only when their serial-select bit is 1 and their port-function bit is 0. With the port-function bit at 1 they carry a timer signal, and otherwise they are general I/O.

The block has two reset inputs. A cold reset clears all stored state. A hot reset clears the port-function and serial-select bits but leaves the extension register as it was, so DMA pin routing survives a warm restart.

Top module: `pin_func_sel`

## Requirements
- R1: Registers are written at a rising clock edge when `wr_en` is 1 and no reset is active. `rdata` shows the addressed register combinationally. Unused bits, and address 3, read as 0. The registers are: address 0, port-function (`NUM_EXT+2` bits); address 1, serial-select (bit 0 ready, bit 1 clock); address 2, extension (`NUM_EXT` bits).
- R2: `cold_rst` clears the port-function, serial-select and extension registers at the next edge, and it takes precedence over `hot_rst` and any write.
- R3: `hot_rst` without `cold_rst` clears the port-function and serial-select registers at the next edge and leaves the extension register unchanged.
- R4: The clock pin, pin index `NUM_EXT+1`, controlled by port-function bit `NUM_EXT+1` and serial-select bit 1, selects serial when the select bit is 1 and the port bit is 0. It selects timer whenever the port bit is 1 and general I/O otherwise.
- R5: The ready pin, pin index `NUM_EXT`, controlled by port-function bit `NUM_EXT` and serial-select bit 0, follows the same rule as R4.
- R6: Extension pin i (0 to `NUM_EXT-1`) selects DMA whenever extension bit i is 1, whatever port-function bit i holds.
- R7: With extension bit i at 0, extension pin i selects serial when port-function bit i is 1 and general I/O when it is 0.
- R8: Pin p drives `pin_fn[4p+3:4p]` with exactly one bit set. The bits are bit 0 general I/O, bit 1 timer, bit 2 serial, bit 3 DMA.
- R9: A write to address 3, or a write issued while either reset is active, leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst | input | 1 | Synchronous cold reset, clears all registers |
| hot_rst | input | 1 | Synchronous hot reset, keeps the extension register |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for write and read |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the addressed register |
| pin_fn | output | 4*(NUM_EXT+2) | One-hot function select per pin |

## Verification
The hardest case to reach from the ports is a hot reset that arrives while the extension register holds a non-zero pattern. The port and select registers must also be set, so that the reset visibly clears them while the DMA routing stays in place. The stimulus first loads all three registers with known values and then pulses `hot_rst` alone. It reads back every address and compares the pin vectors. After that, a long stretch of random writes, reads and occasional hot or cold resets is run against a behavioural model, which compares every pin slice and the read data on each clock.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    typedef enum logic [1:0] {
        FN_GPIO   = 2'd0,
        FN_TIMER  = 2'd1,
        FN_SERIAL = 2'd2,
        FN_DMA    = 2'd3
    } pin_fn_e;

    localparam int FN_COUNT = 4;

    localparam int REG_PORT = 0;
    localparam int REG_SEL  = 1;
    localparam int REG_EXT  = 2;

    localparam int SEL_RDY_BIT = 0;
    localparam int SEL_CLK_BIT = 1;
    localparam int SEL_W       = 2;

    typedef struct packed {
        logic clr_all;   // cold: every register
        logic clr_live;  // cold or hot: port and select registers
    } rst_cmd_t;

    function automatic logic [FN_COUNT-1:0] fn_onehot(pin_fn_e f);
        return FN_COUNT'(1) << f;
    endfunction

    // Extension pin: DMA overrides the port-function bit
    function automatic pin_fn_e decode_ext_pin(logic ext_bit, logic port_bit);
        if (ext_bit)       return FN_DMA;
        else if (port_bit) return FN_SERIAL;
        else               return FN_GPIO;
    endfunction

    // Serial pin: serial only when select is set and port bit is clear
    function automatic pin_fn_e decode_ser_pin(logic sel_bit, logic port_bit);
        if (port_bit)     return FN_TIMER;
        else if (sel_bit) return FN_SERIAL;
        else              return FN_GPIO;
    endfunction

endpackage

// File: rtl/pfs_rst_ctrl.sv
module pfs_rst_ctrl
    import pfs_pkg::*;
(
    input  logic     cold_rst,
    input  logic     hot_rst,
    output rst_cmd_t rst_cmd,
    output logic     wr_block
);
    always_comb begin
        rst_cmd.clr_all  = cold_rst;
        rst_cmd.clr_live = cold_rst | hot_rst;
        wr_block         = cold_rst | hot_rst;
    end
endmodule

// File: rtl/pfs_regs.sv
module pfs_regs
    import pfs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int NUM_EXT = 4
) (
    input  logic                  clk,
    input  rst_cmd_t              rst_cmd,
    input  logic                  wr_block,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_EXT+1:0]    port_q,
    output logic [SEL_W-1:0]      sel_q,
    output logic [NUM_EXT-1:0]    ext_q,
    output logic [DATA_W-1:0]     rdata
);
    localparam int NUM_PINS = NUM_EXT + 2;

    logic wr_ok;
    logic wr_port, wr_sel, wr_ext;

    always_comb begin
        wr_ok   = wr_en && !wr_block;
        wr_port = wr_ok && (int'(addr) == REG_PORT);
        wr_sel  = wr_ok && (int'(addr) == REG_SEL);
        wr_ext  = wr_ok && (int'(addr) == REG_EXT);
    end

    // Port-function and serial-select: cleared by either reset
    always_ff @(posedge clk) begin
        if (rst_cmd.clr_live) begin
            port_q <= '0;
            sel_q  <= '0;
        end else begin
            if (wr_port) port_q <= wdata[NUM_PINS-1:0];
            if (wr_sel)  sel_q  <= wdata[SEL_W-1:0];
        end
    end

    // Extension: cleared by cold reset only
    always_ff @(posedge clk) begin
        if (rst_cmd.clr_all)
            ext_q <= '0;
        else if (wr_ext)
            ext_q <= wdata[NUM_EXT-1:0];
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            REG_PORT: rdata[NUM_PINS-1:0] = port_q;
            REG_SEL:  rdata[SEL_W-1:0]    = sel_q;
            REG_EXT:  rdata[NUM_EXT-1:0]  = ext_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pfs_decode.sv
module pfs_decode
    import pfs_pkg::*;
#(
    parameter int NUM_EXT = 4
) (
    input  logic [NUM_EXT+1:0]                  port_q,
    input  logic [SEL_W-1:0]                    sel_q,
    input  logic [NUM_EXT-1:0]                  ext_q,
    output logic [(NUM_EXT+2)*FN_COUNT-1:0]     pin_fn
);
    localparam int RDY_PIN = NUM_EXT;
    localparam int CLK_PIN = NUM_EXT + 1;

    for (genvar p = 0; p < NUM_EXT; p++) begin : g_ext
        always_comb
            pin_fn[p*FN_COUNT +: FN_COUNT] =
                fn_onehot(decode_ext_pin(ext_q[p], port_q[p]));
    end

    always_comb begin
        pin_fn[RDY_PIN*FN_COUNT +: FN_COUNT] =
            fn_onehot(decode_ser_pin(sel_q[SEL_RDY_BIT], port_q[RDY_PIN]));
        pin_fn[CLK_PIN*FN_COUNT +: FN_COUNT] =
            fn_onehot(decode_ser_pin(sel_q[SEL_CLK_BIT], port_q[CLK_PIN]));
    end
endmodule

// File: rtl/pin_func_sel.sv
module pin_func_sel
    import pfs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int NUM_EXT = 4
) (
    input  logic                              clk,
    input  logic                              cold_rst,
    input  logic                              hot_rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic [(NUM_EXT+2)*FN_COUNT-1:0]   pin_fn
);
    localparam int NUM_PINS = NUM_EXT + 2;

    rst_cmd_t               rst_cmd;
    logic                   wr_block;
    logic [NUM_PINS-1:0]    port_q;
    logic [SEL_W-1:0]       sel_q;
    logic [NUM_EXT-1:0]     ext_q;

    pfs_rst_ctrl u_rst (
        .cold_rst (cold_rst),
        .hot_rst  (hot_rst),
        .rst_cmd  (rst_cmd),
        .wr_block (wr_block)
    );

    pfs_regs #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_EXT (NUM_EXT)
    ) u_regs (
        .clk      (clk),
        .rst_cmd  (rst_cmd),
        .wr_block (wr_block),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .port_q   (port_q),
        .sel_q    (sel_q),
        .ext_q    (ext_q),
        .rdata    (rdata)
    );

    pfs_decode #(
        .NUM_EXT (NUM_EXT)
    ) u_dec (
        .port_q (port_q),
        .sel_q  (sel_q),
        .ext_q  (ext_q),
        .pin_fn (pin_fn)
    );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk
    import pfs_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = 2,
    parameter int NUM_EXT = 4
) (
    input logic                              clk,
    input logic                              cold_rst,
    input logic                              hot_rst,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 addr,
    input logic [DATA_W-1:0]                 wdata,
    input logic [NUM_EXT+1:0]                port_q,
    input logic [SEL_W-1:0]                  sel_q,
    input logic [NUM_EXT-1:0]                ext_q,
    input logic [(NUM_EXT+2)*FN_COUNT-1:0]   pin_fn
);
    localparam int RDY = NUM_EXT;
    localparam int CLK = NUM_EXT + 1;

    logic seen_cold = 1'b0;
    always_ff @(posedge clk)
        if (cold_rst) seen_cold <= 1'b1;

    for (genvar p = 0; p < NUM_EXT + 2; p++) begin : g_oh
        assert_pin_onehot_R8: assert property (@(posedge clk) disable iff (!seen_cold)
            $countones(pin_fn[p*FN_COUNT +: FN_COUNT]) == 1);
    end

    for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
        assert_dma_override_R6: assert property (@(posedge clk) disable iff (!seen_cold)
            ext_q[i] |-> pin_fn[i*FN_COUNT + 3]);
        assert_ext_serial_R7: assert property (@(posedge clk) disable iff (!seen_cold)
            (!ext_q[i] && port_q[i]) |-> pin_fn[i*FN_COUNT + 2]);
        assert_ext_gpio_R7: assert property (@(posedge clk) disable iff (!seen_cold)
            (!ext_q[i] && !port_q[i]) |-> pin_fn[i*FN_COUNT + 0]);
    end

    assert_clk_serial_R4: assert property (@(posedge clk) disable iff (!seen_cold)
        (sel_q[SEL_CLK_BIT] && !port_q[CLK]) |-> pin_fn[CLK*FN_COUNT + 2]);
    assert_clk_timer_R4: assert property (@(posedge clk) disable iff (!seen_cold)
        port_q[CLK] |-> pin_fn[CLK*FN_COUNT + 1]);
    assert_rdy_serial_R5: assert property (@(posedge clk) disable iff (!seen_cold)
        (sel_q[SEL_RDY_BIT] && !port_q[RDY]) |-> pin_fn[RDY*FN_COUNT + 2]);
    assert_rdy_timer_R5: assert property (@(posedge clk) disable iff (!seen_cold)
        port_q[RDY] |-> pin_fn[RDY*FN_COUNT + 1]);

    assert_cold_clear_R2: assert property (@(posedge clk) disable iff (!seen_cold)
        $past(cold_rst) |-> (port_q == '0 && sel_q == '0 && ext_q == '0));
    assert_hot_keep_R3: assert property (@(posedge clk) disable iff (!seen_cold)
        $past(hot_rst && !cold_rst) |->
            (port_q == '0 && sel_q == '0 && ext_q == $past(ext_q)));
    assert_ext_write_R1: assert property (@(posedge clk) disable iff (!seen_cold)
        $past(wr_en && !cold_rst && !hot_rst && int'(addr) == REG_EXT) |->
            ext_q == $past(wdata[NUM_EXT-1:0]));
    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!seen_cold)
        $past(wr_en && !cold_rst && !hot_rst && int'(addr) == 3) |->
            ($stable(port_q) && $stable(sel_q) && $stable(ext_q)));
endmodule

bind pin_func_sel pfs_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_EXT (NUM_EXT)
) u_chk (
    .clk      (clk),
    .cold_rst (cold_rst),
    .hot_rst  (hot_rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .port_q   (port_q),
    .sel_q    (sel_q),
    .ext_q    (ext_q),
    .pin_fn   (pin_fn)
);

// File: tb/pin_func_sel_tb.sv
module pin_func_sel_tb;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 2;
    localparam int NE      = 4;
    localparam int NP      = NE + 2;

    logic               clk = 1'b0;
    logic               cold_rst = 1'b1;
    logic               hot_rst = 1'b0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [DATA_W-1:0]  wdata = '0;
    logic [DATA_W-1:0]  rdata;
    logic [NP*4-1:0]    pin_fn;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // behavioural model state
    int m_port = 0, m_sel = 0, m_ext = 0;
    string rd_tag = "R1";

    always #4 clk = ~clk;  // 125 MHz

    pin_func_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EXT(NE)) u_dut (
        .clk(clk), .cold_rst(cold_rst), .hot_rst(hot_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_fn(pin_fn)
    );

    function automatic int exp_fn(int p);
        int pb = (m_port >> p) & 1;
        if (p < NE) begin
            if ((m_ext >> p) & 1) return 3;
            return pb ? 2 : 0;
        end
        if (pb) return 1;
        if ((m_sel >> (p - NE)) & 1) return 2;
        return 0;
    endfunction

    function automatic int exp_rd(int a);
        case (a)
            0: return m_port;
            1: return m_sel;
            2: return m_ext;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        if (cold_rst) begin
            m_port = 0; m_sel = 0; m_ext = 0;
        end else if (hot_rst) begin
            m_port = 0; m_sel = 0;
        end else if (wr_en) begin
            case (int'(addr))
                0: m_port = int'(wdata) & ((1 << NP) - 1);
                1: m_sel  = int'(wdata) & 3;
                2: m_ext  = int'(wdata) & ((1 << NE) - 1);
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            string t;
            int sl = int'(pin_fn[p*4 +: 4]);
            if (p < NE) t = ((m_ext >> p) & 1) ? "R6" : "R7";
            else if (p == NE) t = "R5";
            else t = "R4";
            check(t, sl, 1 << exp_fn(p));
            check("R8", $countones(pin_fn[p*4 +: 4]), 1);
        end
        check(rd_tag, int'(rdata), exp_rd(int'(addr)));
    endtask

    // one clock: inputs already set, model follows the edge, compare after
    task automatic cycle();
        @(posedge clk);
        model_update();
        #2;
        compare_all();
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic rd_all(string tag);
        rd_tag = tag;
        for (int a = 0; a < 4; a++) begin
            addr = ADDR_W'(a);
            #1;
            check(tag, int'(rdata), exp_rd(a));
        end
        rd_tag = "R1";
    endtask

    initial begin
        // cold reset with a write pending: reset wins (R2, R9)
        rd_tag = "R2";
        wr_en = 1'b1; addr = 2'd2; wdata = 8'hFF;
        cycle(); cycle();
        cold_rst = 1'b0; wr_en = 1'b0;
        rd_all("R2");

        // load registers (R1) and exercise decode (R4 R5 R6 R7)
        wr(0, 8'hFF);
        rd_all("R1");
        wr(1, 8'h03);
        wr(0, 8'h05);
        wr(2, 8'h0A);
        rd_all("R1");
        wr(0, 8'h00);
        cycle();

        // hot reset keeps extension (R3)
        wr(0, 8'h3C);
        hot_rst = 1'b1; wr_en = 1'b1; addr = 2'd2; wdata = 8'h00;
        rd_tag = "R3";
        cycle();
        hot_rst = 1'b0; wr_en = 1'b0;
        rd_all("R3");
        check("R3", m_ext, 8'h0A);

        // unmapped address write has no effect (R9)
        wr(1, 8'h02);
        rd_tag = "R9";
        wr(3, 8'hFF);
        rd_all("R9");

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 99));
            cold_rst = (r < 2);
            hot_rst  = (r >= 2 && r < 6);
            wr_en    = ($urandom_range(0, 1) == 1);
            addr     = ADDR_W'($urandom_range(0, 3));
            wdata    = DATA_W'($urandom_range(0, 255));
            rd_tag   = cold_rst ? "R2" : (hot_rst ? "R3" : "R1");
            cycle();
        end
        cold_rst = 1'b0; hot_rst = 1'b0; wr_en = 1'b0;

        // cold reset after extension loaded clears it (R2)
        wr(2, 8'h0F);
        cold_rst = 1'b1; rd_tag = "R2";
        cycle();
        cold_rst = 1'b0;
        rd_all("R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule